// File: doc/BRIEF.md
# Timed EEPROM Page Erase Controller

This block starts and times the erasure of one page of on-chip non-volatile memory. The command decoder pulses `erase_req_i` in the same cycle it recognises the erase command byte. It does not wait for the bus stop condition. The controller first checks the erase-enable bit of the update configuration byte. It then takes the page number from the EEPROM address pointer that the last address write-word loaded. It issues a one-cycle erase command, with that page number, to the memory array.

A page holds 32 bytes, so the five lowest address bits select a byte within the page and play no part in an erase. While the erase runs, `busy_o` stays high. The bus slave uses this flag to answer every access with NACK. The erase lasts a fixed number of `tick_i` timebase pulses, set by a parameter. The default corresponds to about 20 ms. When the count expires, `busy_o` falls and `done_o` pulses for one cycle.

Top module: `page_erase_ctrl`

## Requirements
- R1: After an asynchronous reset (`rst_ni` low), `busy_o`, `done_o` and `erase_o` are all 0, including when the reset arrives in the middle of an erase.
- R2: A request sampled while bit 2 of `cfg_i` is 0 is ignored: `erase_o` stays 0 and `busy_o` stays 0.
- R3: A request sampled while bit 2 of `cfg_i` is 1 and `busy_o` is 0 starts an erase. In the next cycle `busy_o` goes to 1 and `erase_o` is 1 for exactly that one cycle.
- R4: `erase_page_o` equals `ee_addr_i[15:5]` as sampled with the accepted request. Bits 4:0 of the address have no effect on it.
- R5: While `busy_o` is high, `erase_page_o` holds its value, even if `ee_addr_i` changes.
- R6: `busy_o` stays high until exactly `ERASE_TICKS` cycles with `tick_i` = 1 have been sampled after the start cycle. Cycles with `tick_i` = 0 do not advance the erase.
- R7: When the erase expires, `done_o` is 1 for one cycle, and `busy_o` is 0 in that same cycle.
- R8: A request sampled while `busy_o` is 1 is ignored: no new `erase_o`, no change of page, and no change to when the erase ends. A request in the `done_o` cycle is accepted.
- R9: Bits of `cfg_i` other than bit 2 have no effect on whether an erase starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| erase_req_i | input | 1 | Erase command byte decoded (one-cycle pulse) |
| ee_addr_i | input | 16 | EEPROM address pointer {high byte, low byte} |
| cfg_i | input | 8 | Update configuration byte; bit 2 enables erasing |
| tick_i | input | 1 | Erase timebase pulse |
| erase_o | output | 1 | One-cycle erase command to the memory array |
| erase_page_o | output | 11 | Page number to erase |
| busy_o | output | 1 | Erase in progress; bus accesses get NACK |
| done_o | output | 1 | One-cycle pulse at end of erase |

## Verification
The assertions assume that `erase_req_i` is synchronous to `clk_i`. They also assume that `cfg_i` is a static byte while it is sampled, and that `tick_i` is a single-cycle pulse train. The bench drives every input at the falling edge, so each value is settled before the rising edge that samples it. The bench holds `tick_i` high or pulses it in a fixed pattern, and it lowers reset only between clock edges. The bench also deliberately changes the address and issues requests during an erase, to test the ignore rules under the same assumptions.

// File: rtl/page_erase_pkg.sv
package page_erase_pkg;
  localparam int unsigned ADDR_W      = 16;
  localparam int unsigned PAGE_OFS_W  = 5;  // 32-byte page
  localparam int unsigned PAGE_W      = ADDR_W - PAGE_OFS_W;
  localparam int unsigned CFG_W       = 8;
  localparam int unsigned CFG_EN_BIT  = 2;

  typedef logic [PAGE_W-1:0] page_t;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_ERASE = 1'b1
  } erase_state_e;
endpackage

// File: rtl/erase_accept.sv
module erase_accept
  import page_erase_pkg::*;
(
  input  logic             req_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             busy_i,
  output logic             start_o
);
  logic en;
  assign en      = cfg_i[CFG_EN_BIT];
  assign start_o = req_i & en & ~busy_i;
endmodule

// File: rtl/erase_page_reg.sv
module erase_page_reg
  import page_erase_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output page_t             page_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     page_o <= '0;
    else if (load_i) page_o <= addr_i[ADDR_W-1:PAGE_OFS_W];
  end
endmodule

// File: rtl/erase_timer.sv
module erase_timer #(
  parameter int unsigned TICKS = 2_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i & tick_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (start_i)            cnt_q <= '0;
    else if (run_i && tick_i)    cnt_q <= expire_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/page_erase_ctrl.sv
module page_erase_ctrl
  import page_erase_pkg::*;
#(
  parameter int unsigned ERASE_TICKS = 2_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_req_i,
  input  logic [ADDR_W-1:0] ee_addr_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              tick_i,
  output logic              erase_o,
  output logic [PAGE_W-1:0] erase_page_o,
  output logic              busy_o,
  output logic              done_o
);
  erase_state_e state_q;
  logic start, expire, busy;

  assign busy = (state_q == ST_ERASE);

  erase_accept u_accept (
    .req_i   (erase_req_i),
    .cfg_i   (cfg_i),
    .busy_i  (busy),
    .start_o (start)
  );

  erase_page_reg u_page (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .addr_i (ee_addr_i),
    .page_o (erase_page_o)
  );

  erase_timer #(.TICKS(ERASE_TICKS)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .run_i    (busy),
    .tick_i   (tick_i),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      erase_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      erase_o <= start;
      done_o  <= expire;
      if (start)       state_q <= ST_ERASE;
      else if (expire) state_q <= ST_IDLE;
    end
  end

  assign busy_o = busy;
endmodule

// File: rtl/page_erase_ctrl_chk.sv
module page_erase_ctrl_chk #(
  parameter int unsigned ERASE_TICKS = 2_000_000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        erase_req_i,
  input logic [7:0]  cfg_i,
  input logic        tick_i,
  input logic        erase_o,
  input logic [10:0] erase_page_o,
  input logic        busy_o,
  input logic        done_o
);
  localparam int unsigned CW = $clog2(ERASE_TICKS + 1) + 1;
  logic [CW-1:0] ticks_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ticks_seen <= '0;
    else if (!busy_o) ticks_seen <= '0;
    else if (tick_i)  ticks_seen <= ticks_seen + 1'b1;
  end

  assert_done_ends_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  assert_erase_in_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> erase_o);
  assert_erase_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_o |=> !erase_o);
  assert_disabled_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_req_i && !cfg_i[2] && !busy_o) |=> !busy_o);
  assert_page_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !erase_o) |-> $stable(erase_page_o));
  assert_busy_req_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && erase_req_i) |=> !erase_o);
  assert_duration_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ticks_seen == CW'(ERASE_TICKS)));
endmodule

bind page_erase_ctrl page_erase_ctrl_chk #(.ERASE_TICKS(ERASE_TICKS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .erase_req_i  (erase_req_i),
  .cfg_i        (cfg_i),
  .tick_i       (tick_i),
  .erase_o      (erase_o),
  .erase_page_o (erase_page_o),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/test_page_erase_ctrl.sv
module test_page_erase_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int T = 6;
  localparam int NV = 7;

  // {cfg, addr, expect_start}
  localparam logic [24:0] VEC [NV] = '{
    {8'h04, 16'hF8E0, 1'b1},
    {8'hFF, 16'hF91F, 1'b1},
    {8'hFB, 16'hFA40, 1'b0},  // R9: all bits but 2 set
    {8'h00, 16'hFBFF, 1'b0},
    {8'h84, 16'h001F, 1'b1},
    {8'h06, 16'hFBA5, 1'b1},
    {8'h04, 16'hFBBF, 1'b1}
  };

  logic clk = 0, rst_n = 0, req = 0, tick = 1;
  logic [15:0] addr = '0;
  logic [7:0]  cfg = '0;
  logic erase, busy, done;
  logic [10:0] page;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_erase_ctrl #(.ERASE_TICKS(T)) i_page_erase_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .erase_req_i(req), .ee_addr_i(addr),
    .cfg_i(cfg), .tick_i(tick), .erase_o(erase), .erase_page_o(page),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // issue a request at this negedge; returns at negedge after the sampling edge
  task automatic request(input logic [7:0] c, input logic [15:0] a);
    cfg = c; addr = a; req = 1;
    @(negedge clk); req = 0;
  endtask

  // wait for done; tick pattern: tick only every 'every' cycles; counts ticks while busy
  task automatic run_out(input int every, input string r, input logic [10:0] exp_page);
    int ticks = 0, cyc = 0;
    while (busy && cyc < 200) begin
      chk("R5 page held", page, exp_page);
      tick = ((cyc % every) == 0);
      if (tick) ticks++;
      cyc++;
      @(negedge clk);
    end
    tick = 1;
    chk({r, " done"}, done, 1'b1);
    chk({r, " busy low with done"}, busy, 1'b0);
    chk({r, " ticks"}, ticks, T);
    @(negedge clk);
    chk("R7 done one cycle", done, 1'b0);
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 20000);
        n_fail++; n_run++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none

    @(negedge clk);
    chk("R1 busy reset", busy, 0);
    chk("R1 done reset", done, 0);
    chk("R1 erase reset", erase, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] c; logic [15:0] a; logic s;
      {c, a, s} = VEC[i];
      request(c, a);
      chk(s ? "R3 erase pulse" : "R2/R9 erase ignored", erase, s);
      chk(s ? "R3 busy" : "R2/R9 busy stays low", busy, s);
      if (s) begin
        chk("R4 page", page, a[15:5]);
        addr = ~a;  // R5
        run_out(1, "R6/R7", a[15:5]);
      end else begin
        @(negedge clk);
        chk("R2 still idle", busy, 0);
      end
    end

    // R8: request during busy ignored, end time unchanged
    request(8'h04, 16'hF900);
    request(8'h04, 16'hFB00);
    chk("R8 no second erase", erase, 0);
    chk("R8 page kept", page, 11'h7C8);
    for (int k = 0; k < T - 2; k++) @(negedge clk);
    chk("R8 busy until end", busy, 1);
    @(negedge clk);
    chk("R8 done on time", done, 1);
    // R8: request in done cycle accepted
    request(8'h04, 16'hFA20);
    chk("R8 done-cycle req accepted", erase, 1);
    chk("R4 page new", page, 11'h7D1);
    // R6 sparse ticks
    run_out(3, "R6 sparse", 11'h7D1);

    // R1 reset mid-erase
    request(8'h04, 16'hF840);
    @(negedge clk);
    rst_n = 0; #1;
    chk("R1 mid-erase busy", busy, 0);
    chk("R1 mid-erase done", done, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 stays idle", busy, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule